// File: doc/BRIEF.md
# Instruction Fetch and Call/Return Sequencer

This block holds the program counter and the instruction register of a small 32-bit RISC core and steps every instruction through four phases: a one-cycle fetch request, a wait for the synchronous instruction memory, a one-cycle decode slot, and an execute slot. The execute slot lasts until the rest of the core signals that the instruction is complete. The program counter moves forward by one word during the fetch request. The sequencer also resolves direct subroutine calls and returns. A call stores the address of the following instruction in the link register, which is general register 31, and jumps to an absolute target. A return loads the program counter from that register.

The core around it decodes opcodes and raises `is_call` or `is_ret` together with `exec_done` in the last execute cycle. Register-file writes that target register 31 reach the block through `lr_we`/`lr_wdata`, and register-file reads of it use `lr_value`. States and transitions are ST_FETCH → ST_WAIT (always, after one cycle), ST_WAIT → ST_WAIT (read-valid low), ST_WAIT → ST_DECODE (read-valid high), ST_DECODE → ST_EXEC (always), ST_EXEC → ST_EXEC (exec_done low), and ST_EXEC → ST_FETCH (exec_done high, with any call or return applied on that edge).

Top module: `fseq_top`

## Requirements
- R1: While reset is held, `pc` is 0x0, `instr` holds the no-op word (default 0x00000000), `phase` is 0 (fetch) and `mem_rd` is high.
- R2: `phase` encodes fetch=0, wait=1, decode=2, execute=3. In the fetch phase `mem_rd` is high for exactly one cycle with `mem_addr` equal to `pc`, and after that edge `pc` has grown by 4.
- R3: In the wait phase `mem_rd` is low. While `mem_rvalid` is low, `mem_addr` stays at the fetched address, `instr` keeps its old value and the phase stays at wait.
- R4: A high `mem_rvalid` in the wait phase loads `mem_rdata` into `instr` on that edge. One decode cycle follows, and then the execute phase begins.
- R5: The execute phase, with `mem_rd` low, lasts until `exec_done` is high. The following cycle is a fetch.
- R6: A call (`is_call` with `exec_done`) writes the already-incremented `pc`, which is the call's own address plus 4, into the link register.
- R7: The call target is {pc[31:28] of the incremented pc, instr[31:6], 2'b00}.
- R8: A return (`is_ret` with `exec_done`, no call) loads `pc` from the link register with its low two bits forced to 0.
- R9: `pc` and `mem_addr` always have bits [1:0] equal to 00.
- R10: `lr_we` writes `lr_wdata` into the link register on the next edge, except when a call is taken in that cycle, in which case the call's value wins.
- R11: When `is_call` and `is_ret` are both high, the call is performed and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 32 | Instruction memory address |
| mem_rd | output | 1 | One-cycle read request |
| mem_rdata | input | 32 | Instruction word from memory |
| mem_rvalid | input | 1 | Read data valid |
| instr | output | 32 | Instruction register |
| pc | output | 32 | Program counter |
| phase | output | 2 | Current phase (0 fetch, 1 wait, 2 decode, 3 execute) |
| is_call | input | 1 | Decoded direct call |
| is_ret | input | 1 | Decoded return |
| exec_done | input | 1 | Execute phase complete |
| lr_we | input | 1 | Link register write enable |
| lr_wdata | input | 32 | Link register write data |
| lr_value | output | 32 | Link register contents |

## Verification
The hardest case to reach from the ports is a call whose target depends on the upper four address bits. Those bits change only when the incremented program counter crosses a 256 MiB boundary, and a program starting at zero never gets there. The stimulus writes 0x3FFFFFFC into the link register through its write port and executes a return. It then executes a call from that last word of the region, so the target takes its upper bits from 0x4 instead of 0x3. Later steps collide a call with a return and a link-register write in the same cycle, then return through an unaligned link value.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_WAIT   = 2'd1,
        ST_DECODE = 2'd2,
        ST_EXEC   = 2'd3
    } seq_state_t;

endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
    import fseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rvalid,
    input  logic       exec_done,
    input  logic       is_call,
    input  logic       is_ret,
    output seq_state_t state,
    output logic       fetch_go,
    output logic       ir_load,
    output logic       call_go,
    output logic       ret_go
);

    seq_state_t state_q;
    seq_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:  state_d = ST_WAIT;
            ST_WAIT:   if (rvalid) state_d = ST_DECODE;
            ST_DECODE: state_d = ST_EXEC;
            ST_EXEC:   if (exec_done) state_d = ST_FETCH;
        endcase
    end

    always_comb begin
        fetch_go = 1'b0;
        ir_load  = 1'b0;
        call_go  = 1'b0;
        ret_go   = 1'b0;
        unique case (state_q)
            ST_FETCH:  fetch_go = 1'b1;
            ST_WAIT:   ir_load  = rvalid;
            ST_DECODE: ;
            ST_EXEC: begin
                call_go = exec_done & is_call;
                ret_go  = exec_done & is_ret & ~is_call;
            end
        endcase
    end

    assign state = state_q;

    // R5: execute holds until completion is signalled
    a_r5_exec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && !exec_done) |=> (state_q == ST_EXEC));

    // R4: decode always lasts exactly one cycle
    a_r4_decode_one: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE) |=> (state_q == ST_EXEC));

    // R11: call and return never both fire
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(call_go && ret_go));

endmodule

// File: rtl/fseq_pc.sv
module fseq_pc #(
    parameter int XLEN = 32,
    parameter int OP_W = 6,
    parameter int STEP = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fetch_go,
    input  logic                 call_go,
    input  logic                 ret_go,
    input  logic [XLEN-OP_W-1:0] imm,
    input  logic [XLEN-1:0]      lr_val,
    output logic [XLEN-1:0]      pc,
    output logic [XLEN-1:0]      fetch_addr
);

    localparam int IMM_W = XLEN - OP_W;
    localparam int HI_W  = XLEN - IMM_W - 2;

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_d;
    logic [XLEN-1:0] addr_q;
    logic [XLEN-1:0] call_tgt;

    assign call_tgt = {pc_q[XLEN-1 -: HI_W], imm, 2'b00};

    always_comb begin
        pc_d = pc_q;
        if (fetch_go)     pc_d = pc_q + XLEN'(STEP);
        else if (call_go) pc_d = call_tgt;
        else if (ret_go)  pc_d = {lr_val[XLEN-1:2], 2'b00};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            addr_q <= '0;
        end else begin
            pc_q <= pc_d;
            if (fetch_go) addr_q <= pc_q;
        end
    end

    assign pc         = pc_q;
    assign fetch_addr = addr_q;

    // R9: program counter stays word aligned
    a_r9_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q[1:0] == 2'b00);

    // R2: a fetch advances the counter by one word
    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go |=> (pc_q == $past(pc_q) + XLEN'(STEP)));

endmodule

// File: rtl/fseq_ir.sv
module fseq_ir #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] NOP_WORD = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [XLEN-1:0] rdata,
    output logic [XLEN-1:0] ir
);

    always_ff @(posedge clk) begin
        if (!rst_n)    ir <= NOP_WORD;
        else if (load) ir <= rdata;
    end

    // R3: instruction register only changes on a load
    a_r3_ir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(ir));

endmodule

// File: rtl/fseq_link.sv
module fseq_link #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            call_go,
    input  logic [XLEN-1:0] ret_addr,
    input  logic            we,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] lr
);

    always_ff @(posedge clk) begin
        if (!rst_n)       lr <= '0;
        else if (call_go) lr <= ret_addr;
        else if (we)      lr <= wdata;
    end

    // R10: a plain write lands on the next edge
    a_r10_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !call_go) |=> (lr == $past(wdata)));

endmodule

// File: rtl/fseq_top.sv
module fseq_top
    import fseq_pkg::*;
#(
    parameter int                XLEN     = 32,
    parameter int                OP_W     = 6,
    parameter int                STEP     = 4,
    parameter logic [XLEN-1:0]   NOP_WORD = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] mem_addr,
    output logic            mem_rd,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_rvalid,
    output logic [XLEN-1:0] instr,
    output logic [XLEN-1:0] pc,
    output logic [1:0]      phase,
    input  logic            is_call,
    input  logic            is_ret,
    input  logic            exec_done,
    input  logic            lr_we,
    input  logic [XLEN-1:0] lr_wdata,
    output logic [XLEN-1:0] lr_value
);

    seq_state_t      state;
    logic            fetch_go;
    logic            ir_load;
    logic            call_go;
    logic            ret_go;
    logic [XLEN-1:0] pc_w;
    logic [XLEN-1:0] fetch_addr;
    logic [XLEN-1:0] ir_w;
    logic [XLEN-1:0] lr_w;

    fseq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rvalid    (mem_rvalid),
        .exec_done (exec_done),
        .is_call   (is_call),
        .is_ret    (is_ret),
        .state     (state),
        .fetch_go  (fetch_go),
        .ir_load   (ir_load),
        .call_go   (call_go),
        .ret_go    (ret_go)
    );

    fseq_pc #(.XLEN(XLEN), .OP_W(OP_W), .STEP(STEP)) u_pc (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_go   (fetch_go),
        .call_go    (call_go),
        .ret_go     (ret_go),
        .imm        (ir_w[XLEN-1:OP_W]),
        .lr_val     (lr_w),
        .pc         (pc_w),
        .fetch_addr (fetch_addr)
    );

    fseq_ir #(.XLEN(XLEN), .NOP_WORD(NOP_WORD)) u_ir (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ir_load),
        .rdata (mem_rdata),
        .ir    (ir_w)
    );

    fseq_link #(.XLEN(XLEN)) u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .call_go  (call_go),
        .ret_addr (pc_w),
        .we       (lr_we),
        .wdata    (lr_wdata),
        .lr       (lr_w)
    );

    assign mem_rd   = fetch_go;
    assign mem_addr = fetch_go ? pc_w : fetch_addr;
    assign instr    = ir_w;
    assign pc       = pc_w;
    assign phase    = state;
    assign lr_value = lr_w;

    // R3: address held while the read is outstanding
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !mem_rvalid) |=> $stable(mem_addr));

    // R6: a call saves the incremented counter
    a_r6_link_on_call: assert property (@(posedge clk) disable iff (!rst_n)
        call_go |=> (lr_w == $past(pc_w)));

    // R8: a return resumes at the aligned link value
    a_r8_return: assert property (@(posedge clk) disable iff (!rst_n)
        ret_go |=> (pc_w == ($past(lr_w) & ~XLEN'(3))));

    // R9: every address sent to memory is word aligned
    a_r9_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr[1:0] == 2'b00));

endmodule

// File: tb/tb_fseq_top.sv
module tb_fseq_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr;
    logic        mem_rd;
    logic [31:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] instr;
    logic [31:0] pc;
    logic [1:0]  phase;
    logic        is_call = 1'b0;
    logic        is_ret = 1'b0;
    logic        exec_done = 1'b0;
    logic        lr_we = 1'b0;
    logic [31:0] lr_wdata = '0;
    logic [31:0] lr_value;

    int          n_checks = 0;
    int          n_errors = 0;
    logic [31:0] exp_q[$];
    logic [31:0] exp_pc = '0;
    logic [31:0] exp_lr = '0;
    logic [31:0] prev_ir = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fseq_top dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .instr(instr),
        .pc(pc), .phase(phase), .is_call(is_call), .is_ret(is_ret),
        .exec_done(exec_done), .lr_we(lr_we), .lr_wdata(lr_wdata),
        .lr_value(lr_value)
    );

    task automatic chk(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // Monitor: pops the expected fetch address for every read request
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (rst_n && mem_rd) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected fetch", mem_addr, 32'hx);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(mem_addr == e, "R2 fetch address", mem_addr, e);
                chk(mem_addr[1:0] == 2'b00, "R9 address aligned", mem_addr, e);
            end
        end
    end

    // Driver: one full instruction, starting at a negedge in the fetch phase
    task automatic run_insn(input logic [31:0] word, input int lat,
                            input logic c, input logic r, input int ex,
                            input logic we, input logic [31:0] wd);
        logic [31:0] fa;
        logic [31:0] nxt;
        fa = exp_pc;
        chk(phase == 2'd0 && mem_rd, "R2 fetch phase", {30'b0, phase}, 32'd0);
        tick();
        chk(pc == fa + 32'd4, "R2 pc step", pc, fa + 32'd4);
        chk(!mem_rd && phase == 2'd1, "R3 wait phase", {30'b0, phase}, 32'd1);
        for (int i = 0; i < lat; i++) begin
            chk(mem_addr == fa, "R3 address stable", mem_addr, fa);
            chk(instr == prev_ir, "R3 ir unchanged", instr, prev_ir);
            tick();
            chk(phase == 2'd1, "R3 still waiting", {30'b0, phase}, 32'd1);
        end
        mem_rvalid = 1'b1;
        mem_rdata  = word;
        tick();
        mem_rvalid = 1'b0;
        mem_rdata  = 32'hDEAD_BEEC;
        chk(phase == 2'd2, "R4 decode phase", {30'b0, phase}, 32'd2);
        chk(instr == word, "R4 ir load", instr, word);
        tick();
        chk(phase == 2'd3, "R4 execute phase", {30'b0, phase}, 32'd3);
        for (int i = 0; i < ex; i++) begin
            tick();
            chk(phase == 2'd3 && !mem_rd, "R5 no fetch before done",
                {30'b0, phase}, 32'd3);
        end
        exec_done = 1'b1;
        is_call   = c;
        is_ret    = r;
        lr_we     = we;
        lr_wdata  = wd;
        nxt = fa + 32'd4;
        if (c)      exp_pc = {nxt[31:28], word[31:6], 2'b00};
        else if (r) exp_pc = {exp_lr[31:2], 2'b00};
        else        exp_pc = nxt;
        if (c)       exp_lr = nxt;
        else if (we) exp_lr = wd;
        exp_q.push_back(exp_pc);
        tick();
        exec_done = 1'b0;
        is_call   = 1'b0;
        is_ret    = 1'b0;
        lr_we     = 1'b0;
        prev_ir   = word;
        chk(phase == 2'd0, "R5 back to fetch", {30'b0, phase}, 32'd0);
        if (c)      chk(pc == exp_pc, "R7 call target", pc, exp_pc);
        else if (r) chk(pc == exp_pc, "R8 return target", pc, exp_pc);
        else        chk(pc == exp_pc, "R2 sequential", pc, exp_pc);
        if (c)       chk(lr_value == exp_lr, "R6 link on call", lr_value, exp_lr);
        else if (we) chk(lr_value == exp_lr, "R10 link write", lr_value, exp_lr);
        else         chk(lr_value == exp_lr, "R10 link held", lr_value, exp_lr);
        chk(pc[1:0] == 2'b00, "R9 pc aligned", pc, exp_pc);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        chk(1'b0, "watchdog expired", 32'h0, 32'h0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pc == 32'h0, "R1 reset pc", pc, 32'h0);
        chk(instr == 32'h0, "R1 reset ir", instr, 32'h0);
        chk(phase == 2'd0 && mem_rd, "R1 reset phase", {30'b0, phase}, 32'd0);
        exp_q.push_back(32'h0);
        rst_n = 1'b1;
        // plain instructions, immediate and delayed memory
        run_insn(32'h1111_1100, 0, 0, 0, 0, 0, '0);
        run_insn(32'h2222_2200, 3, 0, 0, 2, 0, '0);
        // call at 0x8 with imm 0x40 -> 0x100, link 0xC
        run_insn({26'h40, 6'h01}, 1, 1, 0, 1, 0, '0);
        run_insn(32'h3333_3300, 2, 0, 0, 0, 0, '0);
        // return resumes at call address + 4
        run_insn(32'h0000_0002, 0, 0, 1, 0, 0, '0);
        chk(pc == 32'h0000_000C, "R8 resume after call", pc, 32'hC);
        // load link register, then return to the end of a region
        run_insn(32'h4444_4400, 0, 0, 0, 1, 1, 32'h3FFF_FFFC);
        run_insn(32'h0000_0002, 1, 0, 1, 0, 0, '0);
        // call from 0x3FFFFFFC: upper bits come from incremented pc (0x4)
        run_insn({26'h123, 6'h01}, 2, 1, 0, 0, 0, '0);
        chk(pc == 32'h4000_048C, "R7 upper bits after increment", pc, 32'h4000_048C);
        // call, return and link write together: call wins
        run_insn({26'h10, 6'h01}, 0, 1, 1, 0, 1, 32'h0BAD_0000);
        chk(lr_value == 32'h4000_0490, "R11 call over return", lr_value, 32'h4000_0490);
        run_insn(32'h0000_0002, 0, 0, 1, 0, 0, '0);
        chk(pc == 32'h4000_0490, "R8 nested resume", pc, 32'h4000_0490);
        // unaligned link value returns aligned
        run_insn(32'h5555_5500, 0, 0, 0, 0, 1, 32'h0000_0203);
        run_insn(32'h0000_0002, 0, 0, 1, 0, 0, '0);
        chk(pc == 32'h0000_0200, "R8 aligned return", pc, 32'h200);
        run_insn(32'h6666_6600, 1, 0, 0, 0, 0, '0);
        tick();
        finish_run();
    end

endmodule